// File: doc/BRIEF.md
# Pin I/O Block with Single Selectable Interrupt Source

This block gives a processor register access to 22 general-purpose pins. Every pin input is brought into the clock domain by a two-flop synchroniser, and software reads it from the input register. An output register supplies the value driven onto each pin. A direction register sets whether each pin's tri-state driver is enabled. The block is reached through a simple word-wide register port. Reads return data one clock after the request.

Only one pin can raise an interrupt at any time. The configuration register holds a 6-bit pin number and a 2-bit trigger mode. The mode can be off, low level, high level or any-edge. In edge mode a change on the selected pin sets a sticky pending flag, and software clears it through a status register. The single request line is meant to be wired into a larger interrupt controller.

Top module: `gpio_sel_irq`

## Requirements
- R1: After reset the output data, direction and configuration registers are zero, so every pin is an input, `pin_oe` and `pin_out` are zero and `irq_req` is low. All registers read back as zero while the pins are low.
- R2: Reading offset 0x00 returns the synchronised pin levels, with pin n at bit n and bits 31..22 at zero. The read data appears on `acc_rdata` one clock after the read request.
- R3: A write to offset 0x08 stores bits 21..0 as the output data. They drive `pin_out` from the next clock and read back at 0x08, with the upper bits at zero.
- R4: A write to offset 0x10 stores the direction. Bit n set to 1 makes pin n an output, which drives `pin_oe[n]` high. Bit n at 0 makes pin n an input.
- R5: A write to offset 0x18 stores the interrupt configuration. Bits 5..0 hold the selected pin number and bits 7..6 hold the trigger mode (0 off, 1 low level, 2 high level, 3 edge). The register reads back in bits 7..0.
- R6: In mode 1, `irq_req` is high while the synchronised level of the selected pin is 0, and it follows that level.
- R7: In mode 2, `irq_req` is high while the synchronised level of the selected pin is 1, and it follows that level.
- R8: In mode 3, a rising or a falling change of the selected pin sets a pending flag. `irq_req` stays high after the pin is stable again. Changes on other pins have no effect.
- R9: Writing 1 to bit 0 at offset 0x1C clears the edge pending flag. Writing 0 there leaves it set. Reading 0x1C returns `irq_req` in bit 0.
- R10: With mode 0, or with a pin number above 21, `irq_req` stays low.
- R11: A selected pin whose direction bit is 1 never raises `irq_req`.
- R12: Writes to offset 0x00 are ignored. They change neither the output pins nor the value that is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Register access request |
| acc_we | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 5 | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid one clock after a read request |
| pin_in | input | 22 | Pin levels from the pads |
| pin_out | output | 22 | Values driven onto the pins |
| pin_oe | output | 22 | Output enable for each pin |
| irq_req | output | 1 | Interrupt request |

## Verification
A wrong pending flag or a wrong stored configuration shows on `irq_req` no later than the clock after the condition arises. A lost flag shows as a drop while the pin is stable. A flag that is never cleared shows as a request that stays high after the clear write. A wrong pin index shows as a request that follows the wrong pin. A wrong synchroniser or register value shows at the next read of its offset. A wrong output or direction register shows on `pin_out` or `pin_oe` one clock after the write.

// File: rtl/gsi_pkg.sv
package gsi_pkg;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_LOW  = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_EDGE = 2'd3
    } trig_mode_e;

    // configuration word, bits [7:6] mode, bits [5:0] pin number
    typedef struct packed {
        trig_mode_e  mode;
        logic [5:0]  sel;
    } irq_cfg_t;

    localparam int unsigned CFG_W = $bits(irq_cfg_t);
    localparam int unsigned SEL_W = 6;

    localparam logic [4:0] OFS_DIN  = 5'h00;
    localparam logic [4:0] OFS_DOUT = 5'h08;
    localparam logic [4:0] OFS_DIR  = 5'h10;
    localparam logic [4:0] OFS_CFG  = 5'h18;
    localparam logic [4:0] OFS_STAT = 5'h1C;

endpackage

// File: rtl/gsi_sync.sv
module gsi_sync #(
    parameter int unsigned W      = 22,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gsi_regs.sv
module gsi_regs
    import gsi_pkg::*;
#(
    parameter int unsigned NPIN   = 22,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [NPIN-1:0]   din_i,
    input  logic              irq_i,
    output logic [NPIN-1:0]   dout_o,
    output logic [NPIN-1:0]   dir_o,
    output irq_cfg_t          cfg_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [NPIN-1:0]   dout;
        logic [NPIN-1:0]   dir;
        irq_cfg_t          cfg;
        logic [DATA_W-1:0] rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_d, rd_d;

    always_comb begin
        st_d  = st_q;
        clr_o = 1'b0;
        wr_d  = acc_en && acc_we;
        rd_d  = acc_en && !acc_we;
        if (wr_d) begin
            case (acc_addr)
                ADDR_W'(OFS_DOUT): st_d.dout = acc_wdata[NPIN-1:0];
                ADDR_W'(OFS_DIR):  st_d.dir  = acc_wdata[NPIN-1:0];
                ADDR_W'(OFS_CFG):  st_d.cfg  = irq_cfg_t'(acc_wdata[CFG_W-1:0]);
                ADDR_W'(OFS_STAT): clr_o     = acc_wdata[0];
                default: ;
            endcase
        end
        if (rd_d) begin
            case (acc_addr)
                ADDR_W'(OFS_DIN):  st_d.rdata = DATA_W'(din_i);
                ADDR_W'(OFS_DOUT): st_d.rdata = DATA_W'(st_q.dout);
                ADDR_W'(OFS_DIR):  st_d.rdata = DATA_W'(st_q.dir);
                ADDR_W'(OFS_CFG):  st_d.rdata = DATA_W'(st_q.cfg);
                ADDR_W'(OFS_STAT): st_d.rdata = DATA_W'(irq_i);
                default:           st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o  = st_q.dout;
    assign dir_o   = st_q.dir;
    assign cfg_o   = st_q.cfg;
    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/gsi_trig.sv
module gsi_trig
    import gsi_pkg::*;
#(
    parameter int unsigned NPIN = 22
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] sync_i,
    input  logic [NPIN-1:0] dir_i,
    input  irq_cfg_t        cfg_i,
    input  logic            clr_i,
    output logic            irq_o
);

    typedef struct packed {
        logic [NPIN-1:0] prev;
        logic            flag;
        logic            irq;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic     hit_d, lvl_d, out_d, chg_d, armed_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        lvl_d = 1'b0;
        out_d = 1'b0;
        chg_d = 1'b0;
        for (int i = 0; i < NPIN; i++) begin
            if (cfg_i.sel == SEL_W'(i)) begin
                hit_d = 1'b1;
                lvl_d = sync_i[i];
                out_d = dir_i[i];
                chg_d = sync_i[i] ^ st_q.prev[i];
            end
        end
        armed_d   = hit_d && !out_d;
        st_d.prev = sync_i;

        // a new change wins over a clear in the same cycle
        if (!armed_d || cfg_i.mode != TRIG_EDGE) begin
            st_d.flag = 1'b0;
        end else if (chg_d) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end

        case (cfg_i.mode)
            TRIG_LOW:  st_d.irq = armed_d && !lvl_d;
            TRIG_HIGH: st_d.irq = armed_d && lvl_d;
            TRIG_EDGE: st_d.irq = st_d.flag;
            default:   st_d.irq = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/gpio_sel_irq.sv
module gpio_sel_irq
    import gsi_pkg::*;
#(
    parameter int unsigned NPIN        = 22,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq_req
);

    logic [NPIN-1:0] sync_w;
    logic [NPIN-1:0] dir_w;
    irq_cfg_t        cfg_w;
    logic            clr_w;
    logic            irq_w;

    gsi_sync #(
        .W      (NPIN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_w)
    );

    gsi_regs #(
        .NPIN   (NPIN),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .din_i     (sync_w),
        .irq_i     (irq_w),
        .dout_o    (pin_out),
        .dir_o     (dir_w),
        .cfg_o     (cfg_w),
        .clr_o     (clr_w),
        .rdata_o   (acc_rdata)
    );

    gsi_trig #(
        .NPIN (NPIN)
    ) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_w),
        .dir_i  (dir_w),
        .cfg_i  (cfg_w),
        .clr_i  (clr_w),
        .irq_o  (irq_w)
    );

    assign pin_oe  = dir_w;
    assign irq_req = irq_w;

endmodule

// File: rtl/gsi_checker.sv
module gsi_checker
    import gsi_pkg::*;
#(
    parameter int unsigned NPIN   = 22,
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [NPIN-1:0]   wdata_lo,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic              irq_req,
    input logic [NPIN-1:0]   sync_lvl,
    input irq_cfg_t          cfg
);

    logic [NPIN-1:0] seen_q;
    logic            sel_chg, sel_out, armed, clr_wr, wr_dout, wr_dir;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= sync_lvl;
    end

    always_comb begin
        sel_chg = 1'b0;
        sel_out = 1'b0;
        armed   = 1'b0;
        for (int i = 0; i < NPIN; i++) begin
            if (int'(cfg.sel) == i) begin
                sel_chg = sync_lvl[i] != seen_q[i];
                sel_out = pin_oe[i];
                armed   = !pin_oe[i];
            end
        end
    end

    assign clr_wr  = acc_en && acc_we && (acc_addr == ADDR_W'(OFS_STAT)) && wdata_lo[0];
    assign wr_dout = acc_en && acc_we && (acc_addr == ADDR_W'(OFS_DOUT));
    assign wr_dir  = acc_en && acc_we && (acc_addr == ADDR_W'(OFS_DIR));

    AST_DOUT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dout |=> pin_out == $past(wdata_lo)); // R3
    AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == $past(wdata_lo)); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == TRIG_OFF) |=> !irq_req); // R10
    AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cfg.sel) >= NPIN) |=> !irq_req); // R10
    AST_OUTPUT_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sel_out |=> !irq_req); // R11
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == TRIG_EDGE && $past(cfg.mode) == TRIG_EDGE && armed && $past(armed)
         && $stable(cfg.sel) && irq_req && !clr_wr) |=> irq_req); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && cfg.mode == TRIG_EDGE && !sel_chg) |=> !irq_req); // R9

endmodule

bind gpio_sel_irq gsi_checker #(
    .NPIN   (NPIN),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (acc_en),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .wdata_lo (acc_wdata[NPIN-1:0]),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq_req  (irq_req),
    .sync_lvl (sync_w),
    .cfg      (cfg_w)
);

// File: tb/gpio_sel_irq_tb_top.sv
module gpio_sel_irq_tb_top;

    localparam int NPIN = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out;
    logic [NPIN-1:0] pin_oe;
    logic        irq_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic     rd_issued = 1'b0;

    always #2 clk = ~clk;

    gpio_sel_irq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_req   (irq_req)
    );

    always @(posedge clk) rd_issued <= acc_en && !acc_we;

    // monitor: compares each read result against the scoreboard
    always @(negedge clk) begin
        if (rd_issued) begin
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read result %h with no expected item", acc_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (acc_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: read got %h expected %h", it.tag, acc_rdata, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic pins(input logic [NPIN-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(32'(pin_out), 32'h0, "R1 pin_out");
        chk(32'(pin_oe),  32'h0, "R1 pin_oe");
        chk(32'(irq_req), 32'h0, "R1 irq_req");
        rd(5'h00, 32'h0, "R1 input reg");
        rd(5'h08, 32'h0, "R1 output reg");
        rd(5'h10, 32'h0, "R1 direction reg");
        rd(5'h18, 32'h0, "R1 config reg");
        rd(5'h1C, 32'h0, "R1 status reg");

        // R2 input read, two patterns
        pins(22'h35A5C3); idle(3);
        rd(5'h00, 32'h0035A5C3, "R2 input pattern A");
        pins(22'h0A5A3C); idle(3);
        rd(5'h00, 32'h000A5A3C, "R2 input pattern B");

        // R12 write to input register ignored
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, 32'h000A5A3C, "R12 input after write");
        chk(32'(pin_out), 32'h0, "R12 pin_out untouched");
        chk(32'(pin_oe),  32'h0, "R12 pin_oe untouched");

        // R3 output data
        wr(5'h08, 32'hFFC1_2345);
        chk(32'(pin_out), 32'h0001_2345, "R3 pin_out");
        rd(5'h08, 32'h0001_2345, "R3 readback");

        // R4 direction
        wr(5'h10, 32'h0000_00F0);
        chk(32'(pin_oe), 32'h0000_00F0, "R4 pin_oe");
        rd(5'h10, 32'h0000_00F0, "R4 readback");
        wr(5'h10, 32'h0);
        chk(32'(pin_oe), 32'h0, "R4 pin_oe back to input");

        // R5 config readback, pin 21 high level
        wr(5'h18, 32'hFFFF_FF95);
        rd(5'h18, 32'h0000_0095, "R5 readback");
        idle(2);
        chk(32'(irq_req), 32'h0, "R5 pin21 low no request");
        pins(22'h200000); idle(4);
        chk(32'(irq_req), 32'h1, "R5 pin21 selected high");

        // R7 high level on pin 3
        pins(22'h0);
        wr(5'h18, 32'h83); idle(4);
        chk(32'(irq_req), 32'h0, "R7 pin3 low");
        pins(22'h000008); idle(4);
        chk(32'(irq_req), 32'h1, "R7 pin3 high");
        rd(5'h1C, 32'h1, "R9 status shows request");
        pins(22'h0); idle(4);
        chk(32'(irq_req), 32'h0, "R7 pin3 back low");

        // R6 low level on pin 3
        wr(5'h18, 32'h43); idle(2);
        chk(32'(irq_req), 32'h1, "R6 pin3 low");
        pins(22'h000008); idle(4);
        chk(32'(irq_req), 32'h0, "R6 pin3 high");
        pins(22'h0); idle(4);
        chk(32'(irq_req), 32'h1, "R6 pin3 low again");

        // R10 mode off and out-of-range pin numbers
        wr(5'h18, 32'h03); idle(2);
        chk(32'(irq_req), 32'h0, "R10 mode off");
        pins(22'h000008); idle(4);
        chk(32'(irq_req), 32'h0, "R10 mode off pin high");
        pins(22'h0);
        wr(5'h18, 32'h56); idle(4);
        chk(32'(irq_req), 32'h0, "R10 pin 22 low level");
        wr(5'h18, 32'h7F); idle(4);
        chk(32'(irq_req), 32'h0, "R10 pin 63 low level");

        // R11 selected pin as output
        wr(5'h10, 32'h20);
        wr(5'h18, 32'h45); idle(4);
        chk(32'(irq_req), 32'h0, "R11 output pin quiet");
        wr(5'h10, 32'h0); idle(2);
        chk(32'(irq_req), 32'h1, "R11 same pin as input");
        wr(5'h18, 32'h0); idle(2);

        // R8 edge on pin 7
        wr(5'h18, 32'hC7); idle(4);
        chk(32'(irq_req), 32'h0, "R8 no edge yet");
        pins(22'h000100); idle(6);
        chk(32'(irq_req), 32'h0, "R8 other pin edge ignored");
        pins(22'h000180); idle(4);
        chk(32'(irq_req), 32'h1, "R8 rising edge");
        idle(10);
        chk(32'(irq_req), 32'h1, "R8 sticky while stable");

        // R9 clear behaviour
        wr(5'h1C, 32'h0); idle(1);
        chk(32'(irq_req), 32'h1, "R9 write 0 keeps flag");
        wr(5'h1C, 32'h1);
        chk(32'(irq_req), 32'h0, "R9 clear drops flag");
        rd(5'h1C, 32'h0, "R9 status after clear");
        idle(4);
        chk(32'(irq_req), 32'h0, "R9 stays clear");
        pins(22'h000100); idle(4);
        chk(32'(irq_req), 32'h1, "R8 falling edge");
        wr(5'h1C, 32'h1);
        chk(32'(irq_req), 32'h0, "R9 second clear");

        idle(4);
        chk(32'(sb_q.size()), 32'h0, "R2 scoreboard drained");
        finish_run();
    end

endmodule